// File: doc/BRIEF.md
# Four-Level FSK Receive Frame Sequencer

This block is the host-side controller that takes a four-level FSK data-pump modem through the reception of one frame. It talks to the modem over a byte-wide register bus with five addresses: control, mode, command, status and data buffer. It also watches the modem's active-low interrupt line. A `go_i` pulse starts a frame. The sequencer loads the control byte and a mode byte, then waits until the carrier has held for enough symbol periods. After that it issues a fixed chain of receive tasks: a frame-sync search, one header block, a runtime-chosen number of intermediate blocks, and one last block.

After each task the sequencer waits for the interrupt and reads the status byte. It checks the flags that apply to that block, then drains the block's bytes from the data buffer onto an output stream. Each output byte carries a block tag and an end-of-block flag. Any failed check stops the frame in a held error state, which keeps an error code and the block index until the next `go_i`. When symbol-event interrupts are enabled, an interrupt reporting a new S symbol is told apart from a task completion. The symbol value is published on its own output and the sequencer keeps waiting for the task to finish.

Top module: `rxf_seq`

## Requirements
- R1: After reset all bus strobes, `ob_valid_o`, `done_o`, `svalue_valid_o` and `err_o` are 0, and no bus access starts until `go_i`.
- R2: On `go_i` the sequencer first writes `ctrl_val_i` to address 0 (control), then writes the mode byte to address 1. The mode byte has bit0 (interrupt enable) = 1, bit4 = `sint_en_i`, bit5 = `invert_i`, and bits 1, 2, 3, 6 and 7 = 0.
- R3: The first command is not written until `carrier_i` has stayed high across 8 `sym_tick_i` pulses. A low `carrier_i` restarts that count.
- R4: Every command write follows a status read (address 3) whose buffer-free bit6 was 1. While bit6 reads 0 the sequencer keeps polling and does not write a command.
- R5: Commands go to address 2 in a fixed order. The first is 0xC1 (sync search, with the clock-acquire bit7 and level-acquire bit6 set). The second is 0x02 (header). Every later command is 0x03 (intermediate/last).
- R6: After a command the sequencer waits for the two-flop-synchronised `irq_n_i` to be low, then reads status. If the status lacks IRQ bit7 or buffer-free bit6, the sequencer stops with error code 3.
- R7: Block byte counts and tags are: station ID 3 bytes, tag 0; header 10 bytes, tag 1; each of `n_mid_i` intermediate blocks 12 bytes, tag 2; last block 8 bytes, tag 3. `n_mid_i` may be 0. Bytes are taken from address 4 in order, and `ob_last_o` marks each block's final byte.
- R8: A status with overflow bit4 = 1 on any block stops the frame with error code 2. None of that block's bytes are output.
- R9: CRC-error bit5 = 1 stops the frame with error code 1 on the station-ID, header and last blocks. On intermediate blocks bit5 is ignored and the block's bytes are output.
- R10: With `sint_en_i` = 1, a status with symbol-ready bit3 = 1 and bit6 = 0 is an S-symbol event. It pulses `svalue_valid_o` with `svalue_o` = status bits[1:0], produces no bytes, and the sequencer waits for the next interrupt of the same task.
- R11: In the error state, `err_o`, `err_code_o` and `err_blk_o` hold until `go_i`, which clears `err_o`. The block index counts station ID as 0, header as 1, intermediate k as 2+k and last as 2+`n_mid_i`.
- R12: `done_o` pulses for one cycle after the last block's final byte.
- R13: A write strobe lasts one cycle. A read strobe lasts one cycle, and the read data is taken two cycles after the strobe rises. The write and read strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start a frame, or leave the error state |
| carrier_i | input | 1 | Carrier present |
| sym_tick_i | input | 1 | One pulse per symbol period |
| n_mid_i | input | 6 | Number of intermediate blocks |
| invert_i | input | 1 | Symbol-invert mode bit |
| sint_en_i | input | 1 | Enable S-symbol event interrupts |
| ctrl_val_i | input | 8 | Byte written to the control register |
| bus_addr_o | output | 3 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_wr_o | output | 1 | One-cycle write strobe |
| bus_rd_o | output | 1 | One-cycle read strobe |
| bus_rdata_i | input | 8 | Registered read data from the modem |
| irq_n_i | input | 1 | Modem interrupt, active low, asynchronous |
| ob_valid_o | output | 1 | Output byte valid |
| ob_data_o | output | 8 | Output byte |
| ob_tag_o | output | 2 | Block tag of the byte |
| ob_last_o | output | 1 | Final byte of its block |
| svalue_valid_o | output | 1 | S-symbol value pulse |
| svalue_o | output | 2 | Latest S-symbol value |
| done_o | output | 1 | Frame completed |
| err_o | output | 1 | Error state held |
| err_code_o | output | 2 | 1 CRC, 2 overflow, 3 bad status |
| err_blk_o | output | 7 | Index of the failing block |

## Verification
The assertions check the bus handshake shape on every cycle: single-cycle strobes that never overlap. They also check that the carrier qualifier only rises after a high carrier and drops when the carrier drops, and that the error outputs stay frozen and the byte stream silent while the error is held. The task order, the command values, the per-block byte counts, tags and data, CRC being ignored on intermediate blocks, and S-symbol interrupts being told apart from task completions can only be shown through the bench's frame scenarios. In those scenarios a modem model injects overflow, CRC, bad-status and buffer-busy conditions on chosen blocks.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0, A_MODE = 3'd1, A_CMD = 3'd2, A_STAT = 3'd3, A_DATA = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {TAG_SID = 2'd0, TAG_HDR = 2'd1, TAG_MID = 2'd2, TAG_LAST = 2'd3} blk_tag_e;
  typedef enum logic [1:0] {E_NONE = 2'd0, E_CRC = 2'd1, E_OVF = 2'd2, E_STAT = 2'd3} err_e;

  // status byte bit positions
  localparam int ST_IRQ   = 7;
  localparam int ST_BFREE = 6;
  localparam int ST_CRC   = 5;
  localparam int ST_OVF   = 4;
  localparam int ST_SRDY  = 3;

  // mode byte bit positions
  localparam int M_IRQEN = 0;
  localparam int M_SINT  = 4;
  localparam int M_INV   = 5;

  localparam logic [7:0] CMD_SYNC = 8'hC1;
  localparam logic [7:0] CMD_HDR  = 8'h02;
  localparam logic [7:0] CMD_BLK  = 8'h03;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b1;
          else     sh_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b1;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rxf_carrier.sv
module rxf_carrier #(
  parameter int SYMS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic carrier_i,
  input  logic tick_i,
  output logic ok_o
);
  localparam int CW = $clog2(SYMS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SYMS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !carrier_i)            cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == LIMIT);
endmodule

// File: rtl/rxf_bus.sv
module rxf_bus
  import rxf_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_wr_i,
  input  logic          req_rd_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_wr_o,
  output logic          bus_rd_o,
  input  logic [DW-1:0] bus_rdata_i
);
  typedef enum logic [1:0] {B_IDLE, B_WR, B_RD1, B_RD2} bst_e;
  bst_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= B_IDLE;
      ack_o       <= 1'b0;
      bus_wr_o    <= 1'b0;
      bus_rd_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      rdata_o     <= '0;
    end else begin
      ack_o    <= 1'b0;
      bus_wr_o <= 1'b0;
      bus_rd_o <= 1'b0;
      case (st_q)
        B_IDLE: begin
          if (!ack_o && req_wr_i) begin
            bus_addr_o  <= req_addr_i;
            bus_wdata_o <= req_wdata_i;
            bus_wr_o    <= 1'b1;
            st_q        <= B_WR;
          end else if (!ack_o && req_rd_i) begin
            bus_addr_o <= req_addr_i;
            bus_rd_o   <= 1'b1;
            st_q       <= B_RD1;
          end
        end
        B_WR: begin
          ack_o <= 1'b1;
          st_q  <= B_IDLE;
        end
        B_RD1: st_q <= B_RD2;
        B_RD2: begin
          rdata_o <= bus_rdata_i;
          ack_o   <= 1'b1;
          st_q    <= B_IDLE;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxf_seq.sv
module rxf_seq
  import rxf_pkg::*;
#(
  parameter int MIDW     = 6,
  parameter int CAR_SYMS = 8,
  parameter int SYNC_N   = 2,
  parameter int SID_N    = 3,
  parameter int HDR_N    = 10,
  parameter int MID_N    = 12,
  parameter int LAST_N   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_i,
  input  logic            carrier_i,
  input  logic            sym_tick_i,
  input  logic [MIDW-1:0] n_mid_i,
  input  logic            invert_i,
  input  logic            sint_en_i,
  input  logic [7:0]      ctrl_val_i,
  output logic [2:0]      bus_addr_o,
  output logic [7:0]      bus_wdata_o,
  output logic            bus_wr_o,
  output logic            bus_rd_o,
  input  logic [7:0]      bus_rdata_i,
  input  logic            irq_n_i,
  output logic            ob_valid_o,
  output logic [7:0]      ob_data_o,
  output logic [1:0]      ob_tag_o,
  output logic            ob_last_o,
  output logic            svalue_valid_o,
  output logic [1:0]      svalue_o,
  output logic            done_o,
  output logic            err_o,
  output logic [1:0]      err_code_o,
  output logic [MIDW:0]   err_blk_o
);
  localparam int BLKW  = MIDW + 1;
  localparam int MAX01 = (SID_N > HDR_N) ? SID_N : HDR_N;
  localparam int MAX23 = (MID_N > LAST_N) ? MID_N : LAST_N;
  localparam int MAXN  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNTW  = (MAXN > 1) ? $clog2(MAXN) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_WCTRL, S_WMODE, S_CARR, S_POLL, S_WCMD, S_WIRQ, S_RSTAT, S_DRAIN, S_DONE, S_ERR
  } st_e;

  st_e st_q;
  logic            car_ok, irq_s_n, ack;
  logic [7:0]      rdata;
  logic            req_wr, req_rd;
  logic [2:0]      req_addr;
  logic [7:0]      req_wdata;
  logic [7:0]      ctrl_q;
  logic [MIDW-1:0] nmid_q;
  logic            inv_q, sint_q;
  logic [BLKW-1:0] blk_q, last_idx;
  logic [CNTW-1:0] cnt_q, need_m1;
  blk_tag_e        kind;
  logic [7:0]      cmd_b, mode_b;

  rxf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d_i(irq_n_i), .q_o(irq_s_n)
  );

  rxf_carrier #(.SYMS(CAR_SYMS)) u_car (
    .clk(clk), .rst(rst), .carrier_i(carrier_i), .tick_i(sym_tick_i), .ok_o(car_ok)
  );

  rxf_bus #(.AW(3), .DW(8)) u_bus (
    .clk(clk), .rst(rst),
    .req_wr_i(req_wr), .req_rd_i(req_rd), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ack_o(ack), .rdata_o(rdata),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i)
  );

  // block kind from index
  assign last_idx = BLKW'(nmid_q) + BLKW'(2);
  always_comb begin
    if (blk_q == '0)                kind = TAG_SID;
    else if (blk_q == BLKW'(1))     kind = TAG_HDR;
    else if (blk_q == last_idx)     kind = TAG_LAST;
    else                            kind = TAG_MID;
  end

  always_comb begin
    case (kind)
      TAG_SID: begin need_m1 = CNTW'(SID_N - 1);  cmd_b = CMD_SYNC; end
      TAG_HDR: begin need_m1 = CNTW'(HDR_N - 1);  cmd_b = CMD_HDR;  end
      TAG_MID: begin need_m1 = CNTW'(MID_N - 1);  cmd_b = CMD_BLK;  end
      default: begin need_m1 = CNTW'(LAST_N - 1); cmd_b = CMD_BLK;  end
    endcase
  end

  always_comb begin
    mode_b          = '0;
    mode_b[M_IRQEN] = 1'b1;
    mode_b[M_SINT]  = sint_q;
    mode_b[M_INV]   = inv_q;
  end

  // bus request for the current state
  always_comb begin
    req_wr    = 1'b0;
    req_rd    = 1'b0;
    req_addr  = A_STAT;
    req_wdata = '0;
    case (st_q)
      S_WCTRL: begin req_wr = 1'b1; req_addr = A_CTRL; req_wdata = ctrl_q; end
      S_WMODE: begin req_wr = 1'b1; req_addr = A_MODE; req_wdata = mode_b; end
      S_WCMD:  begin req_wr = 1'b1; req_addr = A_CMD;  req_wdata = cmd_b;  end
      S_POLL, S_RSTAT: req_rd = 1'b1;
      S_DRAIN: begin req_rd = 1'b1; req_addr = A_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= S_IDLE;
      ctrl_q         <= '0;
      nmid_q         <= '0;
      inv_q          <= 1'b0;
      sint_q         <= 1'b0;
      blk_q          <= '0;
      cnt_q          <= '0;
      ob_valid_o     <= 1'b0;
      ob_data_o      <= '0;
      ob_tag_o       <= '0;
      ob_last_o      <= 1'b0;
      svalue_valid_o <= 1'b0;
      svalue_o       <= '0;
      done_o         <= 1'b0;
      err_o          <= 1'b0;
      err_code_o     <= E_NONE;
      err_blk_o      <= '0;
    end else begin
      ob_valid_o     <= 1'b0;
      svalue_valid_o <= 1'b0;
      done_o         <= 1'b0;
      case (st_q)
        S_IDLE: if (go_i) begin
          ctrl_q <= ctrl_val_i;
          nmid_q <= n_mid_i;
          inv_q  <= invert_i;
          sint_q <= sint_en_i;
          blk_q  <= '0;
          st_q   <= S_WCTRL;
        end
        S_WCTRL: if (ack) st_q <= S_WMODE;
        S_WMODE: if (ack) st_q <= S_CARR;
        S_CARR:  if (car_ok) st_q <= S_POLL;
        S_POLL:  if (ack && rdata[ST_BFREE]) st_q <= S_WCMD;
        S_WCMD:  if (ack) st_q <= S_WIRQ;
        S_WIRQ:  if (!irq_s_n) st_q <= S_RSTAT;
        S_RSTAT: if (ack) begin
          if (sint_q && rdata[ST_SRDY] && !rdata[ST_BFREE]) begin
            svalue_valid_o <= 1'b1;
            svalue_o       <= rdata[1:0];
            st_q           <= S_WIRQ;
          end else if (!rdata[ST_IRQ] || !rdata[ST_BFREE]) begin
            err_code_o <= E_STAT;
            err_blk_o  <= blk_q;
            err_o      <= 1'b1;
            st_q       <= S_ERR;
          end else if (rdata[ST_OVF]) begin
            err_code_o <= E_OVF;
            err_blk_o  <= blk_q;
            err_o      <= 1'b1;
            st_q       <= S_ERR;
          end else if (rdata[ST_CRC] && kind != TAG_MID) begin
            err_code_o <= E_CRC;
            err_blk_o  <= blk_q;
            err_o      <= 1'b1;
            st_q       <= S_ERR;
          end else begin
            cnt_q <= '0;
            st_q  <= S_DRAIN;
          end
        end
        S_DRAIN: if (ack) begin
          ob_valid_o <= 1'b1;
          ob_data_o  <= rdata;
          ob_tag_o   <= kind;
          ob_last_o  <= (cnt_q == need_m1);
          if (cnt_q == need_m1) begin
            if (kind == TAG_LAST) st_q <= S_DONE;
            else begin
              blk_q <= blk_q + 1'b1;
              st_q  <= S_POLL;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DONE: begin
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
        S_ERR: if (go_i) begin
          err_o      <= 1'b0;
          err_code_o <= E_NONE;
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxf_seq_chk.sv
module rxf_seq_chk #(
  parameter int MIDW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          go_i,
  input logic          carrier_i,
  input logic          car_ok,
  input logic          bus_wr_o,
  input logic          bus_rd_o,
  input logic          ob_valid_o,
  input logic          done_o,
  input logic          err_o,
  input logic [1:0]    err_code_o,
  input logic [MIDW:0] err_blk_o
);
  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_o && bus_rd_o));
  p_wr_single_r13: assert property (@(posedge clk) disable iff (rst)
    bus_wr_o |=> !bus_wr_o);
  p_rd_single_r13: assert property (@(posedge clk) disable iff (rst)
    bus_rd_o |=> !bus_rd_o);
  p_car_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(car_ok) |-> $past(carrier_i));
  p_car_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !carrier_i |=> !car_ok);
  p_err_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (err_o && !go_i) |=> (err_o && $stable(err_code_o) && $stable(err_blk_o)));
  p_err_code_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (err_code_o != 2'd0));
  p_no_out_err_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !ob_valid_o);
  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind rxf_seq rxf_seq_chk #(.MIDW(MIDW)) u_chk (
  .clk(clk), .rst(rst), .go_i(go_i), .carrier_i(carrier_i), .car_ok(car_ok),
  .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .ob_valid_o(ob_valid_o),
  .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o), .err_blk_o(err_blk_o)
);

// File: tb/rxf_seq_tb_top.sv
module rxf_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic go = 1'b0, carrier = 1'b1, sym_tick = 1'b0;
  logic [5:0] n_mid = '0;
  logic invert = 1'b0, sint_en = 1'b0;
  logic [7:0] ctrl_val = '0;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = '0;
  logic bus_wr, bus_rd, irq_n = 1'b1;
  logic ob_valid, ob_last, sval_valid, done, err;
  logic [7:0] ob_data;
  logic [1:0] ob_tag, sval, err_code;
  logic [6:0] err_blk;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxf_seq dut_i (
    .clk(clk), .rst(rst), .go_i(go), .carrier_i(carrier), .sym_tick_i(sym_tick),
    .n_mid_i(n_mid), .invert_i(invert), .sint_en_i(sint_en), .ctrl_val_i(ctrl_val),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_wr_o(bus_wr), .bus_rd_o(bus_rd),
    .bus_rdata_i(bus_rdata), .irq_n_i(irq_n),
    .ob_valid_o(ob_valid), .ob_data_o(ob_data), .ob_tag_o(ob_tag), .ob_last_o(ob_last),
    .svalue_valid_o(sval_valid), .svalue_o(sval), .done_o(done),
    .err_o(err), .err_code_o(err_code), .err_blk_o(err_blk)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- reference functions ----------------
  function automatic logic [7:0] gen_byte(int fr, int b, int i);
    return 8'((fr * 37 + b * 11 + i * 5 + 8'h5A) ^ (b << 4));
  endfunction
  function automatic int blk_len(int b, int nm);
    if (b == 0) return 3;
    if (b == 1) return 10;
    if (b == 2 + nm) return 8;
    return 12;
  endfunction
  function automatic int blk_tag(int b, int nm);
    if (b == 0) return 0;
    if (b == 1) return 1;
    if (b == 2 + nm) return 3;
    return 2;
  endfunction
  function automatic logic [7:0] exp_mode(bit iv, bit se);
    return 8'h01 | (se ? 8'h10 : 8'h00) | (iv ? 8'h20 : 8'h00);
  endfunction
  function automatic logic [7:0] exp_cmd(int idx);
    if (idx == 0) return 8'hC1;
    if (idx == 1) return 8'h02;
    return 8'h03;
  endfunction

  // ---------------- scenario ----------------
  int frame_no = 0, sc_nm = 0, sc_ovf = -1, sc_crc = -1, sc_stat = -1, sc_s = -1, sc_bfh = 0;
  bit sc_inv = 0, sc_se = 0;
  logic [7:0] sc_ctrl = '0;
  logic [1:0] sc_sval = '0;

  // symbol tick and reference carrier count
  int tick_c = 0, bcar = 0;
  always @(posedge clk) begin
    tick_c   <= (tick_c + 1) % 4;
    sym_tick <= (tick_c == 3);
    if (!carrier) bcar <= 0;
    else if (sym_tick && bcar < 8) bcar <= bcar + 1;
  end

  // ---------------- modem model ----------------
  int phase = 0, dly = 0, cmd_cnt = 0, cur_blk = 0, rp = 0, bf_hold = 0;
  bit s_done = 0, last_bf = 0, ctrl_seen = 0;
  logic [7:0] stat = 8'h40;
  logic [7:0] dbuf [0:15];

  always @(posedge clk) begin
    if (go) begin
      phase = 0; cmd_cnt = 0; bf_hold = sc_bfh; stat = 8'h40; ctrl_seen = 0; last_bf = 0;
    end
    if (bus_wr) begin
      case (bus_addr)
        3'd0: begin
          chk(bus_wdata == sc_ctrl, "R2 control byte", bus_wdata, sc_ctrl);
          ctrl_seen = 1;
        end
        3'd1: begin
          chk(ctrl_seen && bus_wdata == exp_mode(sc_inv, sc_se), "R2 mode byte after control",
              bus_wdata, exp_mode(sc_inv, sc_se));
        end
        3'd2: begin
          chk(bus_wdata == exp_cmd(cmd_cnt), "R5 command value", bus_wdata, exp_cmd(cmd_cnt));
          chk(last_bf, "R4 command after buffer-free status", last_bf, 1);
          if (cmd_cnt == 0) chk(bcar >= 8, "R3 carrier qualified before first command", bcar, 8);
          cur_blk = cmd_cnt; cmd_cnt++;
          phase = 1; dly = 3 + int'($urandom % 8); stat = 8'h00; s_done = 0; last_bf = 0;
        end
        default: ;
      endcase
    end
    if (bus_rd) begin
      if (bus_addr == 3'd3) begin
        if (phase == 0 && bf_hold > 0) begin
          bus_rdata <= stat & 8'hBF; bf_hold--; last_bf = 0;
        end else begin
          bus_rdata <= stat; last_bf = stat[6];
        end
        irq_n <= 1'b1;
        if (phase == 2) begin phase = 1; dly = 4; stat = 8'h00; end
      end else if (bus_addr == 3'd4) begin
        bus_rdata <= dbuf[rp[3:0]]; rp++;
      end
    end
    if (phase == 1) begin
      dly--;
      if (dly == 0) begin
        if (sc_se && cur_blk == sc_s && !s_done) begin
          stat = 8'h88 | {6'd0, sc_sval}; s_done = 1; phase = 2;
        end else begin
          for (int i = 0; i < 16; i++) dbuf[i] = gen_byte(frame_no, cur_blk, i);
          rp = 0;
          stat = 8'hC0;
          if (cur_blk == sc_crc)  stat[5] = 1'b1;
          if (cur_blk == sc_ovf)  stat[4] = 1'b1;
          if (cur_blk == sc_stat) stat[7] = 1'b0;
          phase = 3;
        end
        irq_n <= 1'b0;
      end
    end
  end

  // ---------------- output monitor ----------------
  int mon_blk = 0, mon_i = 0, got_bytes = 0, sv_cnt = 0;
  bit done_seen = 0, err_seen = 0, prev_wr = 0, prev_rd = 0;
  logic [1:0] sv_last = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_wr && bus_wr) chk(0, "R13 write strobe longer than one cycle", 2, 1);
      if (prev_rd && bus_rd) chk(0, "R13 read strobe longer than one cycle", 2, 1);
      prev_wr = bus_wr; prev_rd = bus_rd;
    end
    if (ob_valid) begin
      chk(ob_data == gen_byte(frame_no, mon_blk, mon_i), "R7 byte value", ob_data,
          gen_byte(frame_no, mon_blk, mon_i));
      chk(ob_tag == blk_tag(mon_blk, sc_nm), "R7 byte tag", ob_tag, blk_tag(mon_blk, sc_nm));
      chk(ob_last == (mon_i == blk_len(mon_blk, sc_nm) - 1), "R7 end-of-block flag", ob_last,
          (mon_i == blk_len(mon_blk, sc_nm) - 1));
      got_bytes++;
      if (mon_i == blk_len(mon_blk, sc_nm) - 1) begin mon_i = 0; mon_blk++; end
      else mon_i++;
    end
    if (sval_valid) begin sv_cnt++; sv_last = sval; end
    if (done) done_seen = 1;
    if (err) err_seen = 1;
  end

  // ---------------- frame runner ----------------
  task automatic run_frame(int nm, bit iv, bit se, int ovfb, int crcb, int statb, int sb, int bfh);
    int eb, ec, nb, cyc;
    @(posedge clk);
    frame_no++; sc_nm = nm; sc_inv = iv; sc_se = se; sc_ovf = ovfb; sc_crc = crcb;
    sc_stat = statb; sc_s = sb; sc_bfh = bfh;
    sc_ctrl = 8'($urandom); sc_sval = 2'($urandom);
    mon_blk = 0; mon_i = 0; got_bytes = 0; sv_cnt = 0; done_seen = 0; err_seen = 0;
    @(negedge clk);
    n_mid = 6'(nm); invert = iv; sint_en = se; ctrl_val = sc_ctrl; go = 1'b1;
    @(negedge clk); go = 1'b0;
    // expected outcome
    eb = -1; ec = 0; nb = 0;
    for (int b = 0; b <= 2 + nm; b++) begin
      if (b == statb) begin eb = b; ec = 3; break; end
      if (b == ovfb)  begin eb = b; ec = 2; break; end
      if (b == crcb && blk_tag(b, nm) != 2) begin eb = b; ec = 1; break; end
      nb += blk_len(b, nm);
    end
    cyc = 0;
    while (!done_seen && !err_seen && cyc < 20000) begin @(negedge clk); cyc++; end
    if (cyc >= 20000) chk(0, "R7 frame finished (watchdog)", cyc, 0);
    repeat (3) @(negedge clk);
    chk(got_bytes == nb, "R7/R8 byte count of frame", got_bytes, nb);
    if (sb >= 0 && se && (eb < 0 || sb <= eb)) begin
      chk(sv_cnt == 1, "R10 one S-symbol event", sv_cnt, 1);
      chk(sv_last == sc_sval, "R10 S-symbol value", sv_last, sc_sval);
    end else begin
      chk(sv_cnt == 0, "R10 no S-symbol event", sv_cnt, 0);
    end
    if (eb < 0) begin
      chk(done_seen && !err_seen, "R12 frame done", done_seen, 1);
    end else begin
      chk(err_seen && !done_seen, "R11 frame error", err_seen, 1);
      chk(err_code == 2'(ec), "R8/R9/R6 error code", err_code, ec);
      chk(err_blk == 7'(eb), "R11 error block index", err_blk, eb);
      repeat (30) @(negedge clk);
      chk(err && err_code == 2'(ec) && err_blk == 7'(eb), "R11 error held", err, 1);
      chk(!ob_valid && !bus_wr && !bus_rd, "R11 quiet in error", ob_valid, 0);
      go = 1'b1; @(negedge clk); go = 1'b0;
      repeat (3) @(negedge clk);
      chk(!err, "R11 restart clears error", err, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1F29));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(!bus_wr && !bus_rd && !ob_valid && !err && !done && !sval_valid,
        "R1 reset state quiet", {bus_wr, bus_rd, ob_valid, err, done}, 0);

    // R3 directed: carrier broken after 5 symbols, then stable
    carrier = 1'b0;
    fork
      run_frame(1, 0, 0, -1, -1, -1, -1, 0);
      begin
        repeat (12) @(negedge clk); carrier = 1'b1;
        repeat (20) @(negedge clk); carrier = 1'b0;
        repeat (6)  @(negedge clk); carrier = 1'b1;
      end
    join
    run_frame(0, 1, 0, -1, -1, -1, -1, 0);   // R7 no intermediate blocks
    run_frame(2, 0, 0, -1,  2, -1, -1, 0);   // R9 CRC ignored on intermediate
    run_frame(2, 0, 0, -1,  0, -1, -1, 0);   // R9 CRC on station ID
    run_frame(1, 0, 0,  1, -1, -1, -1, 0);   // R8 overflow on header
    run_frame(3, 1, 0, -1,  5, -1, -1, 0);   // R9 CRC on last block
    run_frame(1, 0, 0,  2, -1, -1, -1, 0);   // R8 overflow on intermediate
    run_frame(1, 0, 0, -1, -1,  1, -1, 0);   // R6 status missing IRQ bit
    run_frame(2, 0, 1, -1, -1, -1,  2, 4);   // R10 S event, R4 buffer busy
    run_frame(1, 0, 0, -1, -1, -1,  1, 0);   // R10 event ignored when disabled

    for (int t = 0; t < 16; t++) begin
      int nm, lastb, ob, cb, sbk, bh;
      nm = int'($urandom % 4); lastb = 2 + nm;
      ob = -1; cb = -1; sbk = -1;
      case ($urandom % 4)
        0: ob = int'($urandom % (lastb + 1));
        1: cb = int'($urandom % (lastb + 1));
        default: ;
      endcase
      if ($urandom % 2) sbk = int'($urandom % (lastb + 1));
      bh = int'($urandom % 3);
      run_frame(nm, 1'($urandom), 1'($urandom), ob, cb, -1, sbk, bh);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule